// File: doc/BRIEF.md
# Two-Output PWM Timebase Generator

This block generates two pulse-width-modulated outputs from a single up-counting time base. The input clock passes through a two-stage prescaler. One stage divides by a power of two and the other divides by one or by an even number. Together they set how often the counter advances. One period value fixes the frequency that both outputs share. Two compare values each produce their own event when the counter matches them. An action qualifier then turns the wrap, period and compare events into set, clear or toggle actions on each output.

Software programs the block through a simple write port. Period and compare writes land in shadow registers. The block copies them into the active registers when the counter returns to zero, so an update never cuts a pulse short. The prescaler and action words take effect at once. An enable input starts the counter, and dropping the enable freezes both the counter and the outputs.

Top module: `pwm_dual_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pwm_a and pwm_b are 0 and every register is 0. The period is therefore 0 and the counter holds at 0.
- R2: Address 0 holds the prescaler: bits [2:0] are the binary code c and bits [5:3] are the even-step code h. The counter advances once every 2^c × f(h) enabled clock cycles. For example, c=3 with h=2 gives one tick every 32 cycles. The divide counter clears while en is low, so the first tick comes a full interval after en rises.
- R3: The even-step factor f(h) is 1 for h=0 and 2h for h=1..7, which gives 2, 4, 6, 8, 10, 12 and 14.
- R4: On each tick the counter steps up by one. On the tick where it equals the active period, it wraps to 0 instead. The wrap raises a zero event, and arriving at the period value raises a period event. Both outputs share this period.
- R5: While en is low, the counter, pwm_a and pwm_b hold their values.
- R6: Addresses 1, 2 and 3 write the shadow period, the shadow compare A and the shadow compare B. The shadows are copied into the active registers only on a tick that wraps the counter to 0, and the new values already apply to that tick's events.
- R7: Addresses 4 and 5 hold the 8-bit action words for pwm_a and pwm_b. Bits [1:0] act on the zero event, [3:2] on the period event, [5:4] on compare A and [7:6] on compare B. The codes are 00 no action, 01 drive low, 10 drive high and 11 toggle. An output changes on the same clock edge as the counter step that caused it.
- R8: When several events occur on one tick, the output takes the action of the highest-priority event whose code is not 00. The priority order is compare A, then compare B, then period, then zero.
- R9: A compare event fires when the new counter value equals the active compare value. Either compare event can drive either output, and the two compare values are independent.
- R10: Writes to addresses 0, 4 and 5 take effect on the clock edge that follows the write, with no shadowing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run (1) or freeze (0) the time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The assertions assume that wr_addr uses only addresses 0 to 5 and that every write is a single-cycle strobe. They also assume that the programmed compare values lie inside the period whenever an output is expected to toggle. The stimulus stays within these limits: the bench writes each register with a one-cycle pulse on wr_en and only uses defined addresses. It changes the period only through the shadow path while the counter is running, so the check that active registers change only at a counter of zero is never stressed by an illegal input.

// File: rtl/pwm_pkg.sv
// Shared types and register addresses for the two-output PWM generator.
// Assumes a single write port and a fixed 8-bit action word per output.
package pwm_pkg;

    localparam int AQ_W = 8;

    localparam logic [2:0] ADDR_PRESCALE = 3'd0;
    localparam logic [2:0] ADDR_PERIOD   = 3'd1;
    localparam logic [2:0] ADDR_CMP_A    = 3'd2;
    localparam logic [2:0] ADDR_CMP_B    = 3'd3;
    localparam logic [2:0] ADDR_ACT_A    = 3'd4;
    localparam logic [2:0] ADDR_ACT_B    = 3'd5;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TGL  = 2'b11
    } act_code_t;

    typedef struct packed {
        logic cmp_a;
        logic cmp_b;
        logic prd;
        logic zero;
    } tb_events_t;

endpackage

// File: rtl/pwm_prescaler.sv
// Tick prescaler: divides clk by (2^clk_code) * f(hsp_code), where
// f(0)=1 and f(k)=2k. The divide counter clears while en is low.
// Assumes the codes may change at any time; a shrinking divisor fires at once.
module pwm_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] clk_code,
    input  logic [CODE_W-1:0] hsp_code,
    output logic              tick
);
    localparam int MAX_BIN = 1 << ((1 << CODE_W) - 1);
    localparam int MAX_EVN = 2 * ((1 << CODE_W) - 1);
    localparam int DIV_W   = $clog2(MAX_BIN * MAX_EVN + 1);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] evn_fac;
    logic [DIV_W-1:0] div_total;

    // Build the total divisor from the two codes.
    always_comb begin
        evn_fac   = (hsp_code == '0) ? DIV_W'(1) : DIV_W'({hsp_code, 1'b0});
        div_total = evn_fac << clk_code;
        tick      = en && (div_cnt >= div_total - DIV_W'(1));
    end

    // Divide counter: cleared when frozen or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) div_cnt <= '0;
        else                       div_cnt <= div_cnt + DIV_W'(1);
    end

    a_r5_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
    a_r2_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> div_cnt == '0);

endmodule

// File: rtl/pwm_timebase.sv
// Up-counting time base with shadowed period and compare registers.
// Shadows load into the active set on the tick that wraps the counter to 0.
// Events describe the counter value after the current tick.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output tb_events_t       ev
);
    logic [CNT_W-1:0] prd_sh, cmpa_sh, cmpb_sh;
    logic [CNT_W-1:0] prd_act, cmpa_act, cmpb_act;
    logic [CNT_W-1:0] prd_use, cmpa_use, cmpb_use;
    logic [CNT_W-1:0] cnt_nx;
    logic             wrap, load;

    // Next count, shadow load decision and event flags.
    always_comb begin
        wrap     = (cnt == prd_act);
        cnt_nx   = wrap ? '0 : cnt + CNT_W'(1);
        load     = tick && wrap;
        prd_use  = load ? prd_sh  : prd_act;
        cmpa_use = load ? cmpa_sh : cmpa_act;
        cmpb_use = load ? cmpb_sh : cmpb_act;
        ev.zero  = load;
        ev.prd   = tick && (cnt_nx == prd_use);
        ev.cmp_a = tick && (cnt_nx == cmpa_use);
        ev.cmp_b = tick && (cnt_nx == cmpb_use);
    end

    // Shadow registers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_sh  <= '0;
            cmpa_sh <= '0;
            cmpb_sh <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_PERIOD) prd_sh  <= wr_data;
            if (wr_addr == ADDR_CMP_A)  cmpa_sh <= wr_data;
            if (wr_addr == ADDR_CMP_B)  cmpb_sh <= wr_data;
        end
    end

    // Counter step and active-register load at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            prd_act  <= '0;
            cmpa_act <= '0;
            cmpb_act <= '0;
        end else if (tick) begin
            cnt      <= cnt_nx;
            prd_act  <= prd_use;
            cmpa_act <= cmpa_use;
            cmpb_act <= cmpb_use;
        end
    end

    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd_act);
    a_r6_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prd_act) || !$stable(cmpa_act) || !$stable(cmpb_act) |-> cnt == '0);
    a_r5_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tick && cnt == prd_act |=> cnt == '0);

endmodule

// File: rtl/pwm_action.sv
// Action qualifier for one output: picks the highest-priority event with a
// non-idle code (compare A, compare B, period, zero) and applies it.
// Assumes events are single-cycle pulses aligned with the counter step.
module pwm_action
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  tb_events_t      ev,
    input  logic [AQ_W-1:0] ctl,
    output logic            out
);
    act_code_t c_zero, c_prd, c_ca, c_cb, pick;

    // Select the winning action code by priority.
    always_comb begin
        c_zero = act_code_t'(ctl[1:0]);
        c_prd  = act_code_t'(ctl[3:2]);
        c_ca   = act_code_t'(ctl[5:4]);
        c_cb   = act_code_t'(ctl[7:6]);
        if      (ev.cmp_a && c_ca   != ACT_NONE) pick = c_ca;
        else if (ev.cmp_b && c_cb   != ACT_NONE) pick = c_cb;
        else if (ev.prd   && c_prd  != ACT_NONE) pick = c_prd;
        else if (ev.zero  && c_zero != ACT_NONE) pick = c_zero;
        else                                     pick = ACT_NONE;
    end

    // Output register applying the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else begin
            case (pick)
                ACT_LOW:  out <= 1'b0;
                ACT_HIGH: out <= 1'b1;
                ACT_TGL:  out <= ~out;
                default:  out <= out;
            endcase
        end
    end

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ev) |=> $stable(out));
    a_r8_cmpa_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev.cmp_a && ctl[5:4] == 2'b10 |=> out);
    a_r8_cmpa_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev.cmp_a && ctl[5:4] == 2'b01 |=> !out);

endmodule

// File: rtl/pwm_dual_gen.sv
// Two-output PWM generator: prescaler, shared time base and one action
// qualifier per output. Prescale and action words apply immediately;
// period and compare values are shadowed until the counter wraps.
module pwm_dual_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int N_OUT = 2;

    logic [CODE_W-1:0] clk_code, hsp_code;
    logic [AQ_W-1:0]   act_word [N_OUT];
    logic [N_OUT-1:0]  outs;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    tb_events_t        ev;

    // Immediate-effect configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_code    <= '0;
            hsp_code    <= '0;
            act_word[0] <= '0;
            act_word[1] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_PRESCALE) begin
                clk_code <= wr_data[CODE_W-1:0];
                hsp_code <= wr_data[2*CODE_W-1:CODE_W];
            end
            if (wr_addr == ADDR_ACT_A) act_word[0] <= wr_data[AQ_W-1:0];
            if (wr_addr == ADDR_ACT_B) act_word[1] <= wr_data[AQ_W-1:0];
        end
    end

    pwm_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en),
        .clk_code(clk_code), .hsp_code(hsp_code), .tick(tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt(cnt), .ev(ev)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_act
        pwm_action u_act (
            .clk(clk), .rst_n(rst_n), .ev(ev),
            .ctl(act_word[g]), .out(outs[g])
        );
    end

    assign pwm_a = outs[0];
    assign pwm_b = outs[1];

    a_r5_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pwm_a) && $stable(pwm_b));
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !pwm_a && !pwm_b && cnt == '0);

endmodule

// File: tb/pwm_dual_gen_tb_top.sv
// Bench with a behavioural reference model updated on every rising edge
// and compared with both outputs on every falling edge.
module pwm_dual_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int        m_dc, m_cnt, m_prd_s, m_prd_a, m_ca_s, m_ca_a, m_cb_s, m_cb_a;
    int        m_cc, m_hc;
    bit  [7:0] m_ctl [2];
    bit        m_out [2];

    always #10 clk = ~clk;

    pwm_dual_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic bit apply_act(bit [7:0] w, bit cur, bit ez, bit ep, bit ea, bit eb);
        bit [1:0] c;
        if      (ea && w[5:4] != 0) c = w[5:4];
        else if (eb && w[7:6] != 0) c = w[7:6];
        else if (ep && w[3:2] != 0) c = w[3:2];
        else if (ez && w[1:0] != 0) c = w[1:0];
        else                        c = 2'b00;
        case (c)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    // Reference model: one step per clock, writes applied after the step.
    always @(posedge clk) begin
        int  dv;
        bit  tk, wr, ez, ep, ea, eb;
        cyc++;
        if (!rst_n) begin
            m_dc = 0; m_cnt = 0; m_prd_s = 0; m_prd_a = 0; m_ca_s = 0; m_ca_a = 0;
            m_cb_s = 0; m_cb_a = 0; m_cc = 0; m_hc = 0;
            m_ctl[0] = 0; m_ctl[1] = 0; m_out[0] = 0; m_out[1] = 0;
        end else begin
            dv = (1 << m_cc) * ((m_hc == 0) ? 1 : 2 * m_hc);
            tk = 0;
            if (!en) m_dc = 0;
            else if (m_dc >= dv - 1) begin tk = 1; m_dc = 0; end
            else m_dc++;
            if (tk) begin
                wr = (m_cnt == m_prd_a);
                if (wr) begin m_prd_a = m_prd_s; m_ca_a = m_ca_s; m_cb_a = m_cb_s; m_cnt = 0; end
                else m_cnt++;
                ez = wr;
                ep = (m_cnt == m_prd_a);
                ea = (m_cnt == m_ca_a);
                eb = (m_cnt == m_cb_a);
                for (int k = 0; k < 2; k++) m_out[k] = apply_act(m_ctl[k], m_out[k], ez, ep, ea, eb);
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_cc = int'(wr_data[2:0]); m_hc = int'(wr_data[5:3]); end
                    3'd1: m_prd_s = int'(wr_data);
                    3'd2: m_ca_s = int'(wr_data);
                    3'd3: m_cb_s = int'(wr_data);
                    3'd4: m_ctl[0] = wr_data[7:0];
                    3'd5: m_ctl[1] = wr_data[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(cur_req, "pwm_a", int'(pwm_a), int'(m_out[0]));
            check(cur_req, "pwm_b", int'(pwm_b), int'(m_out[1]));
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Rise-to-rise interval of pwm_a in clock cycles.
    task automatic gap_a(output int gap);
        bit prev;
        gap = -1;
        prev = pwm_a;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_a) break;
            prev = pwm_a;
        end
        prev = pwm_a;
        for (int i = 1; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_a) begin gap = i; break; end
            prev = pwm_a;
        end
    endtask

    task automatic high_count_a(int n, output int hc);
        hc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_a) hc++;
        end
    endtask

    initial begin
        int g, h;
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pwm_a after reset", int'(pwm_a), 0);
        check("R1", "pwm_b after reset", int'(pwm_b), 0);
        cmp_on = 1'b1;

        // R4 / R9: divide by 1, period 9, independent compares on A and B.
        cur_req = "R4";
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd9);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd6);
        wr(3'd4, 16'h12);
        wr(3'd5, 16'h42);
        en = 1'b1;
        run(45);
        gap_a(g);
        check("R4", "period of 10 ticks at divide 1", g, 10);

        // R9: cross routing, compare B drives A and compare A drives B.
        cur_req = "R9";
        wr(3'd4, 16'h42);
        wr(3'd5, 16'h12);
        run(40);

        // R6: shrink period through the shadow while running.
        cur_req = "R6";
        wr(3'd4, 16'h12);
        wr(3'd1, 16'd4);
        run(30);
        gap_a(g);
        check("R6", "period after shadow load", g, 5);

        // R5: freeze.
        cur_req = "R5";
        en = 1'b0;
        run(25);
        en = 1'b1;
        run(20);

        // R8 / R7: priority and toggle; compare A at 0 clears over zero set.
        cur_req = "R8";
        wr(3'd1, 16'd5);
        wr(3'd2, 16'd0);
        wr(3'd3, 16'd2);
        wr(3'd4, 16'h1E);
        wr(3'd5, 16'hC0);
        run(20);
        high_count_a(60, h);
        check("R8", "high cycles in 60 (1 per 6)", h, 10);
        cur_req = "R7";
        run(30);

        // R2: divide by 8 * 4 = 32, period 3 -> 128-cycle PWM period.
        cur_req = "R2";
        wr(3'd0, 16'h0013);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd2);
        wr(3'd4, 16'h12);
        run(300);
        gap_a(g);
        check("R2", "period at divide 32", g, 128);
        en = 1'b0;
        run(5);
        en = 1'b1;
        run(140);

        // R3: even-step code 7 -> divide 14; code 1 -> divide 2.
        cur_req = "R3";
        wr(3'd0, 16'h0038);
        run(200);
        gap_a(g);
        check("R3", "period at divide 14", g, 56);
        wr(3'd0, 16'h0008);
        run(40);
        gap_a(g);
        check("R3", "period at divide 2", g, 8);

        // R10: action word takes effect at once: force A high on zero only.
        cur_req = "R10";
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h02);
        run(30);
        check("R10", "pwm_a held high by zero set", int'(pwm_a), 1);

        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule